// File: doc/BRIEF.md
# PLL Power Sequencer

This block steps a phase-locked loop, and optionally a second PLL slaved to it, through power-up and power-down in a fixed order. It drives each PLL's bias enable, its 8-bit system mux code, its output clock gate and its reference buffer enable. It also drives the single start control of the master PLL. It does not model the PLL. It waits on programmed settle times and samples a lock-status input at intervals until a bounded deadline.

A controller raises `pwr_on_req` or `pwr_off_req` for a cycle and then waits for `seq_done`. If the PLL does not report lock in time, the sequencer stops with the output clocks still gated and raises `lock_err`. All intervals are counted in cycles of `clk`. The integrator derives the three timing parameters from the clock rate: about 250 ns of bias settling, a 100 µs poll gap, and enough tries for a 5 ms deadline.

Only plain control and status pins cross the boundary. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `pll_pwr_seq`

## Requirements
- R1: After reset, every control output is 0, both mux codes are 0, `seq_done` is 1 and `lock_err` is 0.
- R2: Power-up first sets the master bias enable and then writes the master mux code 0xC0. If `slave_present` was high when the request was accepted, the slave then gets the same two steps. A mux code only ever holds 0 (off) or 0xC0 (on).
- R3: The next step does not start until at least BIAS_SETTLE_CYC cycles have passed after a mux write of 0xC0 during power-up, or after a bias clear during power-down.
- R4: `pll_start` is set only after the bias steps. `lock_stat` is sampled on the first clock after `pll_start` rises and again every POLL_GAP_CYC+1 cycles, for at most POLL_TRIES+1 samples.
- R5: Once lock is seen, the clock gate is enabled on the master and then on the slave. The reference buffer is then enabled on the master and then on the slave, and `seq_done` returns high.
- R6: If no sample sees lock, `lock_err` rises, the sequence ends, and no clock gate or reference buffer is enabled.
- R7: Power-down on the master runs in this order: clock gate off, `pll_start` off, reference buffer off, mux code 0, bias off, then a settle wait.
- R8: After the master, a slave sampled as present gets clock gate off, reference buffer off, mux code 0, bias off, then a settle wait.
- R9: While `seq_done` is low, requests are ignored. They are not queued.
- R10: A power-on request is accepted only while `pll_start` is 0, and a power-off request only while it is 1. Any other request is ignored. When both requests are high together, the one that fits the present state is taken.
- R11: `lock_err` clears when the next request is accepted. `seq_done` is high exactly while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all intervals are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | Request the power-up sequence |
| pwr_off_req | input | 1 | Request the power-down sequence |
| slave_present | input | 1 | A slave PLL is attached; sampled when a request is accepted |
| lock_stat | input | 1 | Lock indication from the master PLL |
| m_bias_en | output | 1 | Master bias enable |
| m_sys_mux | output | MUX_W | Master system mux code |
| s_bias_en | output | 1 | Slave bias enable |
| s_sys_mux | output | MUX_W | Slave system mux code |
| pll_start | output | 1 | Master PLL start control |
| m_clk_gate_en | output | 1 | Master output clock gate enable |
| s_clk_gate_en | output | 1 | Slave output clock gate enable |
| m_rbuf_en | output | 1 | Master reference buffer enable |
| s_rbuf_en | output | 1 | Slave reference buffer enable |
| seq_done | output | 1 | High while idle and ready to accept a request |
| lock_err | output | 1 | The last power-up timed out waiting for lock |

## Verification
Two things can meet in the same cycle. The first is the last lock sample, where a lock arriving just in time must win over the timeout decision. The bench raises `lock_stat` exactly POLL_TRIES*(POLL_GAP_CYC+1) cycles after `pll_start` is seen; this must end in a clean bring-up. One cycle later must end in `lock_err` with the clocks left gated. The second is a request that lands while a sequence is running, or both requests together. These are provoked directly, and the bench judges them against a model of the expected output edges, logged per cycle.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_UP_BIAS, ST_UP_MUX, ST_UP_SETTLE, ST_UP_START, ST_UP_POLL,
    ST_UP_WAIT, ST_UP_GATE, ST_UP_RBUF, ST_DN_GATE, ST_DN_STOP, ST_DN_RBUF,
    ST_DN_MUX, ST_DN_BIAS, ST_DN_SETTLE
  } seq_st_t;

  typedef enum logic [1:0] {FLD_BIAS, FLD_MUX, FLD_GATE, FLD_RBUF} lane_fld_t;

  typedef struct packed {
    logic      vld;
    lane_fld_t fld;
    logic      val;
  } lane_op_t;
endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pll_seq_lane.sv
module pll_seq_lane
  import pll_seq_pkg::*;
#(
  parameter int             MUX_W  = 8,
  parameter logic [MUX_W-1:0] MUX_ON = 8'hC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  lane_op_t         op,
  output logic             bias_en,
  output logic [MUX_W-1:0] sys_mux,
  output logic             gate_en,
  output logic             rbuf_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bias_en <= 1'b0;
      sys_mux <= '0;
      gate_en <= 1'b0;
      rbuf_en <= 1'b0;
    end else if (op.vld && sel) begin
      case (op.fld)
        FLD_BIAS: bias_en <= op.val;
        FLD_MUX:  sys_mux <= op.val ? MUX_ON : '0;
        FLD_GATE: gate_en <= op.val;
        FLD_RBUF: rbuf_en <= op.val;
        default:  ;
      endcase
    end
  end

  // R2
  mux_needs_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_mux != '0) |-> (bias_en && sys_mux == MUX_ON));
endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
  import pll_seq_pkg::*;
#(
  parameter int               MUX_W           = 8,
  parameter logic [MUX_W-1:0] MUX_ON          = 8'hC0,
  parameter int               BIAS_SETTLE_CYC = 3,
  parameter int               POLL_GAP_CYC    = 5,
  parameter int               POLL_TRIES      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on_req,
  input  logic             pwr_off_req,
  input  logic             slave_present,
  input  logic             lock_stat,
  output logic             m_bias_en,
  output logic [MUX_W-1:0] m_sys_mux,
  output logic             s_bias_en,
  output logic [MUX_W-1:0] s_sys_mux,
  output logic             pll_start,
  output logic             m_clk_gate_en,
  output logic             s_clk_gate_en,
  output logic             m_rbuf_en,
  output logic             s_rbuf_en,
  output logic             seq_done,
  output logic             lock_err
);
  localparam int TMAX = (BIAS_SETTLE_CYC > POLL_GAP_CYC) ? BIAS_SETTLE_CYC : POLL_GAP_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int NW   = $clog2(POLL_TRIES + 1);
  localparam int NL   = 2;

  seq_st_t          st, st_nx;
  logic             ln, ln_nx, slv_q;
  logic [NW-1:0]    tries;
  lane_op_t         op;
  logic             tmr_ld, tmr_exp;
  logic [TW-1:0]    tmr_val;
  logic             acc_on, acc_off, more_slave;
  logic [NL-1:0]    bias_v, gate_v, rbuf_v;
  logic [NL-1:0][MUX_W-1:0] mux_v;

  assign acc_on     = (st == ST_IDLE) && pwr_on_req && !pll_start;
  assign acc_off    = (st == ST_IDLE) && pwr_off_req && pll_start;
  assign more_slave = !ln && slv_q;

  always_comb begin
    st_nx   = st;
    ln_nx   = ln;
    op      = '0;
    tmr_ld  = 1'b0;
    tmr_val = TW'(BIAS_SETTLE_CYC - 1);
    case (st)
      ST_IDLE: begin
        ln_nx = 1'b0;
        if (acc_on)       st_nx = ST_UP_BIAS;
        else if (acc_off) st_nx = ST_DN_GATE;
      end
      ST_UP_BIAS:   begin op = '{1'b1, FLD_BIAS, 1'b1}; st_nx = ST_UP_MUX; end
      ST_UP_MUX:    begin op = '{1'b1, FLD_MUX, 1'b1}; tmr_ld = 1'b1; st_nx = ST_UP_SETTLE; end
      ST_UP_SETTLE: if (tmr_exp) begin
        if (more_slave) begin ln_nx = 1'b1; st_nx = ST_UP_BIAS; end
        else            begin ln_nx = 1'b0; st_nx = ST_UP_START; end
      end
      ST_UP_START:  st_nx = ST_UP_POLL;
      ST_UP_POLL: begin
        if (lock_stat)                     st_nx = ST_UP_GATE;
        else if (tries == NW'(POLL_TRIES)) st_nx = ST_IDLE;
        else begin
          tmr_ld  = 1'b1;
          tmr_val = TW'(POLL_GAP_CYC - 1);
          st_nx   = ST_UP_WAIT;
        end
      end
      ST_UP_WAIT:   if (tmr_exp) st_nx = ST_UP_POLL;
      ST_UP_GATE: begin
        op = '{1'b1, FLD_GATE, 1'b1};
        if (more_slave) ln_nx = 1'b1;
        else begin ln_nx = 1'b0; st_nx = ST_UP_RBUF; end
      end
      ST_UP_RBUF: begin
        op = '{1'b1, FLD_RBUF, 1'b1};
        if (more_slave) ln_nx = 1'b1;
        else begin ln_nx = 1'b0; st_nx = ST_IDLE; end
      end
      ST_DN_GATE:   begin op = '{1'b1, FLD_GATE, 1'b0}; st_nx = ln ? ST_DN_RBUF : ST_DN_STOP; end
      ST_DN_STOP:   st_nx = ST_DN_RBUF;
      ST_DN_RBUF:   begin op = '{1'b1, FLD_RBUF, 1'b0}; st_nx = ST_DN_MUX; end
      ST_DN_MUX:    begin op = '{1'b1, FLD_MUX, 1'b0}; st_nx = ST_DN_BIAS; end
      ST_DN_BIAS:   begin op = '{1'b1, FLD_BIAS, 1'b0}; tmr_ld = 1'b1; st_nx = ST_DN_SETTLE; end
      ST_DN_SETTLE: if (tmr_exp) begin
        if (more_slave) begin ln_nx = 1'b1; st_nx = ST_DN_GATE; end
        else            begin ln_nx = 1'b0; st_nx = ST_IDLE; end
      end
      default:      st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ln        <= 1'b0;
      slv_q     <= 1'b0;
      tries     <= '0;
      pll_start <= 1'b0;
      lock_err  <= 1'b0;
    end else begin
      st <= st_nx;
      ln <= ln_nx;
      if (acc_on || acc_off) begin
        slv_q    <= slave_present;
        lock_err <= 1'b0;
      end
      if (st == ST_UP_START) begin
        pll_start <= 1'b1;
        tries     <= '0;
      end
      if (st == ST_DN_STOP) pll_start <= 1'b0;
      if (st == ST_UP_POLL && !lock_stat) begin
        if (tries == NW'(POLL_TRIES)) lock_err <= 1'b1;
        else                          tries <= tries + 1'b1;
      end
    end
  end

  pll_seq_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .expired(tmr_exp)
  );

  for (genvar i = 0; i < NL; i++) begin : g_lane
    pll_seq_lane #(.MUX_W(MUX_W), .MUX_ON(MUX_ON)) u_lane (
      .clk(clk), .rst_n(rst_n), .sel(ln == 1'(i)), .op(op),
      .bias_en(bias_v[i]), .sys_mux(mux_v[i]), .gate_en(gate_v[i]), .rbuf_en(rbuf_v[i])
    );
  end

  assign m_bias_en     = bias_v[0];
  assign s_bias_en     = bias_v[1];
  assign m_sys_mux     = mux_v[0];
  assign s_sys_mux     = mux_v[1];
  assign m_clk_gate_en = gate_v[0];
  assign s_clk_gate_en = gate_v[1];
  assign m_rbuf_en     = rbuf_v[0];
  assign s_rbuf_en     = rbuf_v[1];
  assign seq_done      = (st == ST_IDLE);

  // R2
  slave_after_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_bias_en) |-> m_bias_en);
  // R4
  start_after_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_start) |-> (m_bias_en && m_sys_mux == MUX_ON));
  // R4
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= NW'(POLL_TRIES));
  // R6
  no_clk_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |-> (!m_clk_gate_en && !m_rbuf_en && !s_clk_gate_en));
  // R7
  gate_before_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_clk_gate_en |-> pll_start);
  // R9
  start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_done) |-> $past(pwr_on_req || pwr_off_req));
endmodule

// File: tb/pll_pwr_seq_tb.sv
module pll_pwr_seq_tb;
  localparam int BS = 3, PG = 5, PT = 4;
  localparam int EDGE = PT * (PG + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_on_req = 1'b0, pwr_off_req = 1'b0, slave_present = 1'b0, lock_stat = 1'b0;
  logic m_bias_en, s_bias_en, pll_start, m_clk_gate_en, s_clk_gate_en;
  logic m_rbuf_en, s_rbuf_en, seq_done, lock_err;
  logic [7:0] m_sys_mux, s_sys_mux;

  pll_pwr_seq #(.BIAS_SETTLE_CYC(BS), .POLL_GAP_CYC(PG), .POLL_TRIES(PT)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .slave_present(slave_present), .lock_stat(lock_stat),
    .m_bias_en(m_bias_en), .m_sys_mux(m_sys_mux), .s_bias_en(s_bias_en), .s_sys_mux(s_sys_mux),
    .pll_start(pll_start), .m_clk_gate_en(m_clk_gate_en), .s_clk_gate_en(s_clk_gate_en),
    .m_rbuf_en(m_rbuf_en), .s_rbuf_en(s_rbuf_en), .seq_done(seq_done), .lock_err(lock_err)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, start_cyc = 0, lock_dly = -1, bad_mux = 0;
  int ev_code[256], ev_cyc[256], ev_n = 0;
  int ex_code[64], ex_n = 0;
  bit mdl[10];
  bit finished = 0;
  logic [9:0] cur, prv = '0;

  // monitor: logs every output edge; field index f (0 bias,1 mux,2 start,3 gate,4 rbuf), lane l
  always @(negedge clk) begin
    cyc++;
    cur = {s_rbuf_en, m_rbuf_en, s_clk_gate_en, m_clk_gate_en, 1'b0, pll_start,
           |s_sys_mux, |m_sys_mux, s_bias_en, m_bias_en};
    if (rst_n) begin
      for (int i = 0; i < 10; i++)
        if (cur[i] != prv[i] && ev_n < 256) begin
          ev_code[ev_n] = i * 2 + int'(cur[i]);
          ev_cyc[ev_n]  = cyc;
          ev_n++;
          if (i == 4 && cur[i]) start_cyc = cyc;
        end
      if (!(m_sys_mux == 8'h00 || m_sys_mux == 8'hC0)) bad_mux++;
      if (!(s_sys_mux == 8'h00 || s_sys_mux == 8'hC0)) bad_mux++;
    end
    prv = cur;
    lock_stat <= pll_start && lock_dly >= 0 && (cyc - start_cyc) >= lock_dly;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic e(input int f, input int l, input bit v);
    if (mdl[f*2+l] != v) begin
      mdl[f*2+l] = v;
      ex_code[ex_n] = (f*2+l)*2 + int'(v);
      ex_n++;
    end
  endtask

  task automatic exp_up(input bit slv, input bit ok);
    e(0,0,1); e(1,0,1);
    if (slv) begin e(0,1,1); e(1,1,1); end
    e(2,0,1);
    if (ok) begin
      e(3,0,1); if (slv) e(3,1,1);
      e(4,0,1); if (slv) e(4,1,1);
    end
  endtask

  task automatic exp_down(input bit slv);
    e(3,0,0); e(2,0,0); e(4,0,0); e(1,0,0); e(0,0,0);
    if (slv) begin e(3,1,0); e(4,1,0); e(1,1,0); e(0,1,0); end
  endtask

  task automatic wait_done();
    int g = 0;
    while (!seq_done && g < 3000) begin @(negedge clk); g++; end
  endtask

  task automatic pulse(input bit on, input bit off, input bit slv, input int ld);
    @(negedge clk);
    lock_dly = ld; slave_present = slv; pwr_on_req = on; pwr_off_req = off;
    @(negedge clk);
    pwr_on_req = 0; pwr_off_req = 0;
    wait_done();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_log(input int first, input string rq);
    int n = ev_n - first;
    bit ok = (n == ex_n);
    int bad = -1;
    for (int i = 0; i < ex_n && ok; i++)
      if (ev_code[first+i] != ex_code[i]) begin ok = 0; bad = i; end
    if (bad >= 0) chk(0, rq, ev_code[first+bad], ex_code[bad]);
    else          chk(ok, rq, n, ex_n);
    // R3 settle after mux-on and bias-off
    for (int i = first; i + 1 < ev_n; i++)
      if (ev_code[i] == 5 || ev_code[i] == 7 || ev_code[i] == 0 || ev_code[i] == 2)
        chk((ev_cyc[i+1] - ev_cyc[i]) >= BS, "R3 settle gap", ev_cyc[i+1] - ev_cyc[i], BS);
  endtask

  task automatic do_up(input bit slv, input int ld, input string rq);
    int first = ev_n;
    bit ok = (ld >= 0 && ld <= EDGE);
    ex_n = 0;
    exp_up(slv, ok);
    pulse(1, 0, slv, ld);
    chk_log(first, rq);
    chk(lock_err == !ok, "R6 lock_err after power-up", int'(lock_err), int'(!ok));
    chk(seq_done == 1'b1, "R11 done after power-up", int'(seq_done), 1);
  endtask

  task automatic do_down(input bit slv, input string rq);
    int first = ev_n;
    ex_n = 0;
    exp_down(slv);
    pulse(0, 1, slv, -1);
    chk_log(first, rq);
    chk(lock_err == 1'b0, "R11 lock_err cleared by accepted request", int'(lock_err), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int first;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({m_bias_en, s_bias_en, pll_start, m_clk_gate_en, s_clk_gate_en, m_rbuf_en, s_rbuf_en} == '0,
        "R1 controls low in reset", 1, 0);
    chk(m_sys_mux == 0 && s_sys_mux == 0, "R1 mux codes zero", int'(m_sys_mux), 0);
    chk(seq_done && !lock_err, "R1 done high, no error", int'(seq_done), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R5 R7 R8 directed with slave
    do_up(1, 2, "R2 R5 up with slave");
    chk(m_sys_mux == 8'hC0 && s_sys_mux == 8'hC0, "R2 mux code value", int'(s_sys_mux), 8'hC0);
    do_down(1, "R7 R8 down with slave");

    // R4 boundary: lock seen exactly at final sample
    do_up(0, EDGE, "R4 lock at last sample");
    do_down(0, "R7 down after boundary");
    // R4 R6 one cycle too late
    do_up(1, EDGE + 1, "R6 lock one cycle late");
    chk(m_clk_gate_en == 0 && m_rbuf_en == 0, "R6 clocks stay gated", int'(m_clk_gate_en), 0);

    // R10 power-on ignored while pll_start is set
    first = ev_n; ex_n = 0;
    pulse(1, 0, 1, 0);
    chk_log(first, "R10 on ignored when started");
    chk(lock_err == 1'b1, "R10 ignored request keeps lock_err", int'(lock_err), 1);
    do_down(1, "R8 R11 down after lock error");

    // R9 request during a running sequence is dropped
    first = ev_n; ex_n = 0; exp_up(1, 1);
    @(negedge clk); lock_dly = 0; slave_present = 1; pwr_on_req = 1;
    @(negedge clk); pwr_on_req = 0;
    repeat (2) @(negedge clk); pwr_off_req = 1;
    @(negedge clk); pwr_off_req = 0;
    wait_done(); repeat (2) @(negedge clk);
    chk_log(first, "R9 busy request ignored");
    chk(pll_start == 1'b1, "R9 sequence not reversed", int'(pll_start), 1);

    // R10 both requests while up: off taken
    first = ev_n; ex_n = 0; exp_down(1);
    pulse(1, 1, 1, -1);
    chk_log(first, "R10 both requests while up");
    // R10 both requests while down: on taken
    first = ev_n; ex_n = 0; exp_up(0, 1);
    pulse(1, 1, 0, 3);
    chk_log(first, "R10 both requests while down");
    // R10 power-off ignored while already down is checked after a down
    do_down(0, "R7 down");
    first = ev_n; ex_n = 0;
    pulse(0, 1, 1, -1);
    chk_log(first, "R10 off ignored when stopped");

    // random sweep
    for (int k = 0; k < 14; k++) begin
      bit slv = 1'($urandom_range(0, 1));
      int ld = ($urandom_range(0, 3) == 0) ? -1 : int'($urandom_range(0, EDGE + 8));
      do_up(slv, ld, "R4 R5 R6 random up");
      do_down(slv, "R7 R8 random down");
    end

    chk(bad_mux == 0, "R2 mux code only 0 or C0", bad_mux, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule